// File: doc/BRIEF.md
# Randomized Keep-Alive Load Pulser

This block drives one load-enable line so that a battery pack with automatic shut-off sees a short burst of current draw at irregular intervals and stays on. The line alternates between a brief active pulse and a long idle gap. A fresh length for each phase is drawn from a built-in pseudo-random source, so the pattern never settles into a fixed period.

The length of a phase is counted in ticks. Ticks come from a two-stage divider: a fixed prescaler, then a compare stage whose terminal value depends on the phase. A fine tick times the pulse and a coarse tick times the gap, so one narrow count register covers both. The window bounds in ticks are worked out at elaboration time from the clock frequency and the millisecond limits. A one-cycle tick strobe is brought out so that a watchdog or a debug probe can follow the block. While the enable is low the load line is forced off and all state holds.

Top module: `keepalive_pulser`

## Requirements
- R1: When reset is released the phase is high and its tick count is the first draw from SEED. With en_i high, load_o is 1 and tick_o is 0 during reset.
- R2: tick_o is a one-cycle strobe. In a phase it first goes high after PRESCALE*TOP_HIGH enabled clocks (high phase) or PRESCALE*TOP_LOW enabled clocks (low phase), and then again after each further such period. Both divider stages restart from zero at each phase change.
- R3: A high phase lasts N ticks, with N in [HI_MIN_T, HI_MAX_T] and HI_x_T = HI_x_MS*CLK_HZ/(1000*PRESCALE*TOP_HIGH), rounded down and capped at 2^CNT_W-1.
- R4: A low phase lasts N ticks, with N in [LO_MIN_T, LO_MAX_T], computed the same way with the LO_x_MS limits and TOP_LOW.
- R5: Each tick lowers the remaining count by one. load_o toggles on the clock edge that consumes the last tick, so a phase of N ticks holds load_o for exactly N tick periods of enabled clocks.
- R6: The random state is a 32-bit xorshift that applies x^=x<<13, then x^=x>>17, then x^=x<<5, starting from SEED (a SEED of zero is replaced by 1). A draw uses the current state and then advances it once. The draw gives N = min + (state mod (max-min+1)), and a result of 0 becomes 1.
- R7: While en_i is 0, load_o and tick_o are 0, and the count, phase and divider counters hold. Enabled operation then resumes exactly where it stopped.
- R8: With en_i high, load_o never stays in one state for more than the window maximum times that phase's tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces the load off and freezes all state |
| load_o | output | 1 | Load-enable line |
| tick_o | output | 1 | One-cycle tick strobe |

## Verification
tick_o and load_o are decoded from registers, with en_i gating both, so a tick or a toggle caused by the clock edge at cycle k appears at the ports in cycle k. A change of en_i shows on both outputs in the same cycle. The bench samples on the falling edge. Before it changes en_i, it compares the outputs with a cycle-exact model that counts enabled clock edges, not elapsed time. The model keeps the elapsed clocks in the phase, the phase length in clocks and its own xorshift state. Each measured phase is also checked against its tick window, and the running length of the current phase is checked against its ceiling.

// File: rtl/kap_pkg.sv
package kap_pkg;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  function automatic logic [31:0] xs32_next(logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // lo + (s mod span), never zero
  function automatic logic [31:0] draw_ticks(logic [31:0] s, logic [31:0] lo, logic [31:0] span);
    logic [31:0] v;
    v = lo + (s % span);
    if (v == 32'd0) v = 32'd1;
    return v;
  endfunction

  function automatic longint ms_to_ticks(longint ms, longint hz, longint pre, longint top, longint cap);
    longint t;
    t = (ms * hz) / (longint'(1000) * pre * top);
    return (t > cap) ? cap : t;
  endfunction

endpackage

// File: rtl/kap_tick_gen.sv
module kap_tick_gen
  import kap_pkg::*;
#(
  parameter int unsigned PRESCALE = 256,
  parameter int unsigned TOP_HIGH = 1,
  parameter int unsigned TOP_LOW  = 255
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  phase_e phase_i,
  input  logic   restart_i,
  output logic   tick_o
);
  localparam int unsigned TOP_MAX = (TOP_HIGH > TOP_LOW) ? TOP_HIGH : TOP_LOW;
  localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned DV_W = (TOP_MAX > 1) ? $clog2(TOP_MAX) : 1;

  logic [PS_W-1:0] ps_q;
  logic [DV_W-1:0] dv_q;
  logic            ps_last;
  logic [DV_W-1:0] dv_last;

  assign ps_last = (ps_q == PS_W'(PRESCALE - 1));
  assign dv_last = (phase_i == PH_HIGH) ? DV_W'(TOP_HIGH - 1) : DV_W'(TOP_LOW - 1);
  assign tick_o  = en_i && ps_last && (dv_q == dv_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q <= '0;
      dv_q <= '0;
    end else if (en_i) begin
      if (restart_i) begin
        // phase change: drop partial period
        ps_q <= '0;
        dv_q <= '0;
      end else begin
        ps_q <= ps_last ? '0 : ps_q + PS_W'(1);
        if (ps_last) dv_q <= (dv_q == dv_last) ? '0 : dv_q + DV_W'(1);
      end
    end
  end

endmodule

// File: rtl/kap_rng.sv
module kap_rng
  import kap_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter logic [31:0] SEED_NZ = 32'h1,
  parameter logic [31:0] HI_MIN  = 32'd1,
  parameter logic [31:0] HI_SPAN = 32'd1,
  parameter logic [31:0] LO_MIN  = 32'd1,
  parameter logic [31:0] LO_SPAN = 32'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  phase_e           phase_i,
  output logic [CNT_W-1:0] draw_o
);
  logic [31:0]      st_q;
  logic [CNT_W-1:0] hi_draw;
  logic [CNT_W-1:0] lo_draw;

  // constant divisors: two fixed reducers, then select
  assign hi_draw = CNT_W'(draw_ticks(st_q, HI_MIN, HI_SPAN));
  assign lo_draw = CNT_W'(draw_ticks(st_q, LO_MIN, LO_SPAN));
  assign draw_o  = (phase_i == PH_HIGH) ? hi_draw : lo_draw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        st_q <= xs32_next(SEED_NZ); // seed used by reset draw
    else if (advance_i) st_q <= xs32_next(st_q);
  end

endmodule

// File: rtl/kap_phase_ctrl.sv
module kap_phase_ctrl
  import kap_pkg::*;
#(
  parameter int unsigned      CNT_W    = 16,
  parameter logic [CNT_W-1:0] INIT_CNT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] draw_i,
  output phase_e           phase_o,
  output phase_e           next_phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign expire_o     = tick_i && (cnt_q <= CNT_W'(1));
  assign next_phase_o = (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
  assign phase_o      = phase_q;
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HIGH;
      cnt_q   <= INIT_CNT;
    end else if (expire_o) begin
      phase_q <= next_phase_o;
      cnt_q   <= draw_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/keepalive_pulser.sv
module keepalive_pulser
  import kap_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 8000000,
  parameter int unsigned PRESCALE  = 256,
  parameter int unsigned TOP_HIGH  = 1,
  parameter int unsigned TOP_LOW   = 255,
  parameter int unsigned HI_MIN_MS = 2,
  parameter int unsigned HI_MAX_MS = 6,
  parameter int unsigned LO_MIN_MS = 40000,
  parameter int unsigned LO_MAX_MS = 55000,
  parameter int unsigned CNT_W     = 16,
  parameter logic [31:0] SEED      = 32'h2545_f491
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic load_o,
  output logic tick_o
);
  localparam longint      CAP     = (longint'(1) << CNT_W) - 1;
  localparam logic [31:0] HI_MIN_T = 32'(ms_to_ticks(HI_MIN_MS, CLK_HZ, PRESCALE, TOP_HIGH, CAP));
  localparam logic [31:0] HI_MAX_T = 32'(ms_to_ticks(HI_MAX_MS, CLK_HZ, PRESCALE, TOP_HIGH, CAP));
  localparam logic [31:0] LO_MIN_T = 32'(ms_to_ticks(LO_MIN_MS, CLK_HZ, PRESCALE, TOP_LOW, CAP));
  localparam logic [31:0] LO_MAX_T = 32'(ms_to_ticks(LO_MAX_MS, CLK_HZ, PRESCALE, TOP_LOW, CAP));
  localparam logic [31:0] HI_SPAN  = HI_MAX_T - HI_MIN_T + 32'd1;
  localparam logic [31:0] LO_SPAN  = LO_MAX_T - LO_MIN_T + 32'd1;
  localparam logic [31:0] SEED_NZ  = (SEED == 32'd0) ? 32'd1 : SEED;
  localparam logic [CNT_W-1:0] INIT_CNT = CNT_W'(draw_ticks(SEED_NZ, HI_MIN_T, HI_SPAN));

  phase_e           phase_q;
  phase_e           next_phase;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] draw;
  logic             tick;
  logic             expire;
  logic             load_q;

  kap_tick_gen #(
    .PRESCALE(PRESCALE),
    .TOP_HIGH(TOP_HIGH),
    .TOP_LOW (TOP_LOW)
  ) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .phase_i  (phase_q),
    .restart_i(expire),
    .tick_o   (tick)
  );

  kap_rng #(
    .CNT_W  (CNT_W),
    .SEED_NZ(SEED_NZ),
    .HI_MIN (HI_MIN_T),
    .HI_SPAN(HI_SPAN),
    .LO_MIN (LO_MIN_T),
    .LO_SPAN(LO_SPAN)
  ) u_rng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .advance_i(expire),
    .phase_i  (next_phase),
    .draw_o   (draw)
  );

  kap_phase_ctrl #(
    .CNT_W   (CNT_W),
    .INIT_CNT(INIT_CNT)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .draw_i      (draw),
    .phase_o     (phase_q),
    .next_phase_o(next_phase),
    .cnt_o       (cnt_q),
    .expire_o    (expire)
  );

  assign load_q = (phase_q == PH_HIGH);
  assign load_o = en_i & load_q;
  assign tick_o = tick;

endmodule

// File: rtl/keepalive_pulser_chk.sv
module keepalive_pulser_chk #(
  parameter int unsigned CNT_W      = 16,
  parameter logic [31:0] HI_MAX     = 32'd1,
  parameter logic [31:0] LO_MAX     = 32'd1,
  parameter int unsigned MIN_PERIOD = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             load_o,
  input logic             tick_o,
  input logic             phase_i,
  input logic [CNT_W-1:0] cnt_i
);

  assert_idle_outputs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!load_o && !tick_o));

  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_i) && $stable(phase_i)));

  assert_toggle_on_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && cnt_i <= CNT_W'(1)) |=> (phase_i != $past(phase_i)));

  assert_hold_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_o && cnt_i <= CNT_W'(1)) |=> $stable(phase_i));

  assert_cnt_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |-> (cnt_i != '0 && 32'(cnt_i) <= HI_MAX));

  assert_cnt_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i |-> (cnt_i != '0 && 32'(cnt_i) <= LO_MAX));

  generate
    if (MIN_PERIOD >= 2) begin : g_single
      assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

bind keepalive_pulser keepalive_pulser_chk #(
  .CNT_W     (CNT_W),
  .HI_MAX    (HI_MAX_T),
  .LO_MAX    (LO_MAX_T),
  .MIN_PERIOD(PRESCALE * TOP_HIGH)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .load_o (load_o),
  .tick_o (tick_o),
  .phase_i(load_q),
  .cnt_i  (cnt_q)
);

// File: tb/keepalive_pulser_tb_top.sv
module keepalive_pulser_tb_top;
  localparam longint CLK_HZ = 10000;
  localparam longint PS     = 2;
  localparam longint TH     = 1;
  localparam longint TL     = 5;
  localparam longint HMIN_MS = 2, HMAX_MS = 6, LMIN_MS = 400, LMAX_MS = 550;
  localparam logic [31:0] SEED = 32'h1234_5678;
  localparam int NCYC = 120000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic load, tick;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keepalive_pulser #(
    .CLK_HZ(CLK_HZ), .PRESCALE(PS), .TOP_HIGH(TH), .TOP_LOW(TL),
    .HI_MIN_MS(HMIN_MS), .HI_MAX_MS(HMAX_MS), .LO_MIN_MS(LMIN_MS), .LO_MAX_MS(LMAX_MS),
    .CNT_W(16), .SEED(SEED)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_o(load), .tick_o(tick)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    return x;
  endfunction

  function automatic longint to_ticks(longint ms, longint top);
    return (ms * CLK_HZ) / (1000 * PS * top);
  endfunction

  function automatic longint draw(logic [31:0] s, longint mn, longint mx);
    longint v = mn + (longint'(s) % (mx - mn + 1));
    return (v == 0) ? 1 : v;
  endfunction

  longint hmin_t, hmax_t, lmin_t, lmax_t;
  bit m_load, last_load;
  longint m_len, m_el, run, t_cur, t_prev, first_t, per, perp, t;
  logic [31:0] m_rng;
  int off_left = 0, nphase = 0;
  bit exp_load, exp_tick;

  initial begin : watchdog
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd7));
    hmin_t = to_ticks(HMIN_MS, TH); hmax_t = to_ticks(HMAX_MS, TH);
    lmin_t = to_ticks(LMIN_MS, TL); lmax_t = to_ticks(LMAX_MS, TL);

    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk(load == 1'b1, "R1", "load in reset", load, 1);
    chk(tick == 1'b0, "R1", "tick in reset", tick, 0);
    rst_n = 1'b1;

    m_rng = SEED;
    t_cur = draw(m_rng, hmin_t, hmax_t);
    first_t = t_cur;
    t_prev = 0;
    m_rng = xs(m_rng);
    m_load = 1'b1; m_len = t_cur * PS * TH; m_el = 0;
    last_load = 1'b1; run = 0;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      per = m_load ? PS * TH : PS * TL;
      exp_load = en ? m_load : 1'b0;
      exp_tick = en && ((m_el % per) == per - 1);
      chk(load == exp_load, en ? "R5" : "R7", "load_o", load, exp_load);
      chk(tick == exp_tick, en ? "R2" : "R7", "tick_o", tick, exp_tick);

      if (en && load != last_load) begin
        perp = last_load ? PS * TH : PS * TL;
        t = run / perp;
        chk((run % perp) == 0, "R5", "phase not whole ticks", run, t * perp);
        if (last_load) chk(t >= hmin_t && t <= hmax_t, "R3", "high ticks", t, hmin_t);
        else           chk(t >= lmin_t && t <= lmax_t, "R4", "low ticks", t, lmin_t);
        chk(t == t_prev, "R6", "drawn ticks", t, t_prev);
        if (nphase == 0) chk(t == first_t, "R1", "first high ticks", t, first_t);
        nphase++;
        last_load = load;
        run = 0;
      end
      if (en) begin
        perp = last_load ? PS * TH * hmax_t : PS * TL * lmax_t;
        chk(run <= perp, "R8", "phase overrun", run, perp);
      end

      // enable schedule: directed gaps then random
      if (cyc >= 15 && cyc <= 22) en = 1'b0;
      else if (cyc >= 60000 && cyc <= 60002) en = 1'b0;
      else begin
        if (off_left == 0 && $urandom_range(0, 199) == 0) off_left = $urandom_range(1, 40);
        if (off_left > 0) begin en = 1'b0; off_left--; end
        else en = 1'b1;
      end

      // model the coming edge
      if (en) begin
        run++;
        if (m_el + 1 == m_len) begin
          m_load = ~m_load;
          t_prev = t_cur;
          t_cur = m_load ? draw(m_rng, hmin_t, hmax_t) : draw(m_rng, lmin_t, lmax_t);
          m_rng = xs(m_rng);
          m_len = t_cur * (m_load ? PS * TH : PS * TL);
          m_el = 0;
        end else begin
          m_el++;
        end
      end
      @(negedge clk);
    end

    chk(nphase >= 10, "R5", "phase count", nphase, 10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule